// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the 12-bit operand address for memory-reference instructions in a machine whose address space is split into 32 pages of 128 words. When an instruction word has been fetched, the block captures the 7-bit in-page offset and the page-select bit from the instruction register. In the same cycle it captures the page number of the instruction's own address, taken from the upper five bits of the memory address register. Later, in the operand-read state, a strobe makes the block register the effective address. A one-cycle valid pulse then marks the new value.

The page number is taken at fetch time from the address the instruction was read from, never from the program counter. The program counter has already been incremented by the time the address is formed. An instruction in the last word of a page (octal 0177, for example) that refers to its own page must therefore stay in that page, even though the counter has moved on to the next one. The opcode and indirect bits of the instruction word are not inputs to the block, so they can never be used as a page number.

A two-state controller runs the block. IDLE means no instruction is held. ARMED means an instruction's fields have been captured and are waiting for the operand-read strobe. The transitions are: IDLE to ARMED on the fetch strobe ("arm"); ARMED to ARMED on a fetch strobe without the operand-read strobe ("re-arm", which captures the newer instruction); and ARMED to IDLE on the operand-read strobe ("issue").

Top module: `paged_ea_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `ea` is 0, `ea_valid` is 0 and the controller is IDLE.
- R2: Bits [6:0] of an issued `ea` equal bits [6:0] of `ir_low` as captured on the fetch strobe.
- R3: When the captured page-select bit (`ir_low[7]`) is 0, bits [11:7] of the issued `ea` are 0 (page zero).
- R4: When the captured page-select bit is 1, bits [11:7] of the issued `ea` equal `ma_page` as sampled on the fetch strobe. Later changes of `ma_page`, such as the counter moving into the next page, have no effect.
- R5: An operand-read strobe seen in ARMED loads `ea` at that clock edge and raises `ea_valid` for exactly one cycle.
- R6: `ea` holds its value in every cycle in which `ea_valid` is 0.
- R7: An operand-read strobe in IDLE is ignored: `ea_valid` stays 0 and `ea` keeps its value.
- R8: A fetch strobe in ARMED without an operand-read strobe replaces the held fields with the newer instruction's fields.
- R9: When both strobes arrive in the same cycle in ARMED, the held instruction is issued, the fetch strobe is ignored and the controller returns to IDLE.
- R10: The controller moves IDLE to ARMED on a fetch strobe and ARMED to IDLE on an operand-read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_stb | input | 1 | Instruction word valid; capture fields and page |
| ir_low | input | 8 | Instruction bits: [7] page-select, [6:0] offset |
| ma_page | input | 5 | Upper five bits of the memory address register |
| opread_stb | input | 1 | Operand-read state strobe |
| ea | output | 12 | Registered effective address |
| ea_valid | output | 1 | One-cycle pulse when `ea` is updated |

## Verification
The assertions assume that the strobes are synchronous to `clk` and free of X after reset. They make no assumption about spacing between strobes. The stimulus drives every input on the falling edge only, and it covers both strobes together, an operand-read strobe with nothing held, and back-to-back fetches. Page sweeps use the first, middle and last word of several pages with both page-select settings. Opcode-like upper bits are made to differ from the page, and `ma_page` is advanced after each fetch, so a wrong page source shows up as a mismatch.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
    typedef enum logic [0:0] {
        EA_IDLE  = 1'b0,
        EA_ARMED = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import paged_ea_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fetch_stb,
    input  logic      opread_stb,
    output logic      capture_en,
    output logic      issue_en,
    output ea_state_e state
);
    ea_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EA_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            EA_IDLE:  if (fetch_stb)  state_nx = EA_ARMED;
            EA_ARMED: if (opread_stb) state_nx = EA_IDLE;
            default:  state_nx = EA_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture_en = 1'b0;
        issue_en   = 1'b0;
        unique case (state)
            EA_IDLE:  capture_en = fetch_stb;
            EA_ARMED: begin
                issue_en   = opread_stb;
                capture_en = fetch_stb && !opread_stb;
            end
            default: ;
        endcase
    end

    assert_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EA_IDLE && fetch_stb) |=> (state == EA_ARMED));
    assert_issue_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EA_ARMED && opread_stb) |=> (state == EA_IDLE));
endmodule

// File: rtl/ea_capture.sv
module ea_capture #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 7,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [OFS_W:0]    ir_low,
    input  logic [PAGE_W-1:0] ma_page,
    output logic [PAGE_W-1:0] page_q,
    output logic [OFS_W-1:0]  ofs_q,
    output logic              psel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            psel_q <= 1'b0;
        end else if (capture_en) begin
            page_q <= ma_page;
            ofs_q  <= ir_low[OFS_W-1:0];
            psel_q <= ir_low[OFS_W];
        end
    end
endmodule

// File: rtl/ea_compose.sv
module ea_compose #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 7,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic [PAGE_W-1:0] page_q,
    input  logic [OFS_W-1:0]  ofs_q,
    input  logic              psel_q,
    output logic [ADDR_W-1:0] ea_next
);
    assign ea_next[OFS_W-1:0] = ofs_q;
    for (genvar b = 0; b < PAGE_W; b++) begin : g_page_bit
        assign ea_next[OFS_W+b] = page_q[b] & psel_q;
    end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
    import paged_ea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 7,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic [OFS_W:0]    ir_low,
    input  logic [PAGE_W-1:0] ma_page,
    input  logic              opread_stb,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid
);
    logic              capture_en, issue_en, psel_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [ADDR_W-1:0] ea_next;
    ea_state_e         state;

    ea_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .opread_stb(opread_stb),
        .capture_en(capture_en), .issue_en(issue_en), .state(state)
    );

    ea_capture #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .ir_low(ir_low),
        .ma_page(ma_page), .page_q(page_q), .ofs_q(ofs_q), .psel_q(psel_q)
    );

    ea_compose #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_comp (
        .page_q(page_q), .ofs_q(ofs_q), .psel_q(psel_q), .ea_next(ea_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= issue_en;
            if (issue_en) ea <= ea_next;
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);
    assert_valid_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ea_valid) |-> $past(opread_stb));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_valid |-> $stable(ea));
    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EA_IDLE) |=> !ea_valid);
    assert_page_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && !psel_q) |-> (ea[ADDR_W-1:OFS_W] == '0));
    assert_page_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && psel_q) |-> (ea[ADDR_W-1:OFS_W] == page_q));
    assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> (ea[OFS_W-1:0] == ofs_q));
endmodule

// File: tb/paged_ea_gen_bench.sv
module paged_ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [7:0]  ir_low = '0;
    logic [4:0]  ma_page = '0;
    logic        opread_stb = 1'b0;
    logic [11:0] ea;
    logic        ea_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase_tag = "R1";

    // reference model state
    bit        m_armed = 0;
    bit        m_valid = 0;
    int        m_ea = 0;
    int        m_page = 0, m_ofs = 0;
    bit        m_ps = 0;

    always #10 clk = ~clk;

    paged_ea_gen u_paged_ea_gen (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .ir_low(ir_low),
        .ma_page(ma_page), .opread_stb(opread_stb), .ea(ea), .ea_valid(ea_valid)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    // model update at every edge, compare 5 ns later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_valid = 0; m_ea = 0; m_page = 0; m_ofs = 0; m_ps = 0;
        end else if (m_armed && opread_stb) begin
            m_ea    = m_ps ? (m_page * 128 + m_ofs) : m_ofs;
            m_valid = 1;
            m_armed = 0;
        end else begin
            m_valid = 0;
            if (fetch_stb) begin
                m_page  = ma_page;
                m_ofs   = ir_low % 128;
                m_ps    = ir_low[7];
                m_armed = 1;
            end
        end
        #5;
        check({phase_tag, " ea"}, ea, m_ea);
        check({phase_tag, " ea_valid"}, ea_valid, m_valid);
    end

    // fetch an instruction at address {pg,word}; then advance MA; then opread
    task automatic run_instr(int pg, int word, bit ps, int gap, string tag);
        int ofs, expv;
        ofs = (word * 37 + pg) % 128;
        expv = ps ? pg * 128 + ofs : ofs;
        phase_tag = tag;
        @(negedge clk);
        fetch_stb = 1; ma_page = pg[4:0]; ir_low = {ps, ofs[6:0]};
        @(negedge clk);
        fetch_stb = 0; ma_page = (word == 127) ? pg[4:0] + 5'd1 : ~pg[4:0];
        ir_low = {~ps, ~ofs[6:0]};
        repeat (gap) @(negedge clk);
        opread_stb = 1;
        @(posedge clk); #5;
        check({tag, " directed ea"}, ea, expv);
        check("R5 pulse high", ea_valid, 1);
        @(negedge clk);
        opread_stb = 0;
        @(posedge clk); #5;
        check("R5 pulse low", ea_valid, 0);
    endtask

    initial begin
        int pages[6] = '{0, 1, 7, 16, 30, 31};
        int words[3] = '{0, 64, 127};
        repeat (2) @(posedge clk);
        #5;
        check("R1 reset ea", ea, 0);
        check("R1 reset valid", ea_valid, 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #5;
        check("R1 after release", ea_valid, 0);

        // R7: opread strobe in IDLE
        phase_tag = "R7";
        @(negedge clk); opread_stb = 1;
        @(negedge clk); opread_stb = 0;
        check("R7 idle opread ea", ea, 0);
        check("R7 idle opread valid", ea_valid, 0);

        // R4: instruction at octal 0177 on its own page
        run_instr(0, 127, 1, 1, "R4");
        check("R4 0177 page", ea >> 7, 0);
        run_instr(0, 127, 0, 0, "R3");

        // page sweep with both page-select settings (R2 R3 R4)
        foreach (pages[i]) foreach (words[j]) begin
            run_instr(pages[i], words[j], 1, j, "R4");
            run_instr(pages[i], words[j], 0, 1, "R3");
        end

        // R7 again: ea held from last issue after idle opread
        phase_tag = "R7";
        @(negedge clk); opread_stb = 1;
        @(negedge clk); opread_stb = 0;
        check("R7 hold after issue", ea, 31 * 128 + (127 * 37 + 31) % 128 - 31 * 128 + ((127 * 37 + 31) % 128 == 0 ? 0 : 0));

        // R8: back-to-back fetches, newest wins
        phase_tag = "R8";
        @(negedge clk); fetch_stb = 1; ma_page = 5'd3; ir_low = 8'h85;
        @(negedge clk); ma_page = 5'd9; ir_low = 8'hA2;
        @(negedge clk); fetch_stb = 0; opread_stb = 1;
        @(posedge clk); #5;
        check("R8 newest fetch", ea, 9 * 128 + 8'h22);
        @(negedge clk); opread_stb = 0;

        // R9: both strobes together in ARMED
        phase_tag = "R9";
        @(negedge clk); fetch_stb = 1; ma_page = 5'd12; ir_low = 8'h81;
        @(negedge clk); ma_page = 5'd20; ir_low = 8'h8F; opread_stb = 1;
        @(posedge clk); #5;
        check("R9 held instruction issued", ea, 12 * 128 + 1);
        @(negedge clk); fetch_stb = 0;
        @(negedge clk); opread_stb = 0;
        check("R9 second opread ignored", ea_valid, 0);
        check("R9 ea kept", ea, 12 * 128 + 1);

        // R6 quiet cycles
        phase_tag = "R6";
        repeat (5) @(negedge clk);
        check("R6 quiet hold", ea, 12 * 128 + 1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL R10 watchdog expired actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule